// File: doc/BRIEF.md
# External Memory Write-Cycle Sequencer

This block drives write accesses to an asynchronous external memory such as an SRAM. A write request is taken through a valid/ready handshake with an address and a data word. The block then plays out one write cycle whose length is a whole number of clock cycles. During that cycle it drives the address, the data word with its output enable, an active-low write strobe and an active-low chip select.

Each strobe has its own setup (the clocks before it falls) and its own pulse (the clocks it stays low). Both strobes share one cycle length. The hold time of a strobe is whatever is left over: cycle length minus setup minus pulse. A control-select input says which strobe governs the write, and the data output enable follows the setup of that strobe. Writes can follow one another with no idle clock. A strobe with zero setup and no hold therefore stays low across a whole run of writes.

The block checks the timing settings all the time. If they are illegal it raises an error output and refuses new requests.

Top module: `extmem_wr_seq`

## Requirements
- R1: With cycle length N (`cfg_cycle`), an accepted write keeps the block busy for exactly N clocks, counted 0 to N-1. `req_ready` is high on clock N-1 and whenever the block is idle, provided `cfg_err` is low.
- R2: Within a write, each strobe is low exactly on the clocks whose count k satisfies setup <= k < setup+pulse. It is high for the remaining hold clocks (N - setup - pulse) at the end of the cycle.
- R3: A request that is present on clock N-1 starts the next write on the very next clock, with count 0. A strobe with setup 0 and setup+pulse = N then stays low, with no high clock, across the whole run of writes.
- R4: When no write is in progress, `mem_we_n` and `mem_cs_n` are both high and `mem_doe` is low. This includes the state right after reset.
- R5: With `cfg_we_ctrl` = 1 (write strobe governs), `mem_doe` is high from count = write-strobe setup up to and including count N-1, and low before that.
- R6: With `cfg_we_ctrl` = 0 (chip select governs), `mem_doe` is high from count = chip-select setup up to and including count N-1, and low before that.
- R7: `mem_addr` and `mem_dout` take the request's address and data on the clock the request is accepted. They stay constant for the whole write and change only when a new write is accepted.
- R8: A pulse of zero on either strobe sets `cfg_err`. `req_ready` is then low and no write starts.
- R9: Setup plus pulse greater than the cycle length, on either strobe, sets `cfg_err` and blocks new writes.
- R10: When the governing strobe has setup 0 and hold 0, `cfg_err` is set. The same settings on the non-governing strobe are legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cycle | input | CNT_W | Write cycle length in clocks |
| cfg_we_setup | input | CNT_W | Clocks before the write strobe falls |
| cfg_we_pulse | input | CNT_W | Clocks the write strobe stays low |
| cfg_cs_setup | input | CNT_W | Clocks before chip select falls |
| cfg_cs_pulse | input | CNT_W | Clocks chip select stays low |
| cfg_we_ctrl | input | 1 | 1: write strobe governs the data enable, 0: chip select governs |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request is accepted on this clock if valid |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| mem_addr | output | ADDR_W | Address bus to memory |
| mem_dout | output | DATA_W | Data bus to memory |
| mem_doe | output | 1 | Data bus output enable |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_cs_n | output | 1 | Chip select, active low |
| cfg_err | output | 1 | Timing settings are illegal |

## Verification
The strobes, the data enable and the ready signal are all decoded from a single cycle counter. A counter that is off by one shows at the ports in the same clock: a strobe edge or the enable edge lands one clock early or late, or ready rises on the wrong clock and the next write starts misaligned. A busy flag that lingers or drops early shows as strobes low while idle, or as a lost back-to-back start within one clock. A wrongly latched address or data word is visible for the whole cycle that follows it. Because the bench compares every output against its reference on every clock, none of these faults can hide for more than one cycle.

// File: rtl/extmem_wr_pkg.sv
package extmem_wr_pkg;
   // which strobe decides when the data bus is driven
   typedef enum logic {
      CTRL_BY_CS = 1'b0,
      CTRL_BY_WE = 1'b1
   } wr_ctrl_e;

   // strobe slot indices inside the sequencer
   localparam int STRB_WE  = 0;
   localparam int STRB_CS  = 1;
   localparam int NUM_STRB = 2;
endpackage

// File: rtl/wr_cycle_ctrl.sv
module wr_cycle_ctrl #(
   parameter int CNT_W  = 6,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cycle_len,
   input  logic              cfg_err,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              busy,
   output logic [CNT_W-1:0]  cnt,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic              busy_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              last;
   logic              accept;

   assign last      = busy_q && (cnt_q == cycle_len - ONE);
   assign req_ready = !cfg_err && (!busy_q || last);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         addr_q <= req_addr;
         data_q <= req_data;
      end else if (last) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q + ONE;
      end
   end

   assign busy = busy_q;
   assign cnt  = cnt_q;

   // cycle ends after exactly cycle_len clocks when nothing follows
   assert_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !req_valid) |=> !busy_q);

   // a request on the final clock starts the next cycle at once
   assert_no_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (last && accept) |=> (busy_q && cnt_q == '0));

   // address and data frozen inside a cycle
   assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != '0) |-> ($stable(addr_q) && $stable(data_q)));

   // an illegal setting never starts a cycle from idle
   assert_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !busy_q) |=> !busy_q);
endmodule

// File: rtl/wr_strobe_gen.sv
module wr_strobe_gen #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cycle_len,
   input  logic [CNT_W-1:0] setup,
   input  logic [CNT_W-1:0] pulse,
   input  logic             governs,
   output logic             strobe_n,
   output logic             past_setup,
   output logic             bad_cfg
);
   localparam int SUM_W = CNT_W + 1;

   logic [SUM_W-1:0] fall_at;
   logic [SUM_W-1:0] rise_at;
   logic [SUM_W-1:0] len_x;
   logic             in_pulse;

   assign fall_at  = {1'b0, setup};
   assign rise_at  = {1'b0, setup} + {1'b0, pulse};
   assign len_x    = {1'b0, cycle_len};
   assign in_pulse = ({1'b0, cnt} >= fall_at) && ({1'b0, cnt} < rise_at);

   assign strobe_n   = !(active && in_pulse);
   assign past_setup = active && (cnt >= setup);

   // zero pulse, overrun of the cycle, or no edge margin on the governing strobe
   assign bad_cfg = (pulse == '0)
                 || (rise_at > len_x)
                 || (governs && (setup == '0) && (rise_at == len_x));

   // strobe is never low before its own setup has elapsed
   assert_setup_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_n |-> past_setup);
endmodule

// File: rtl/extmem_wr_seq.sv
module extmem_wr_seq
   import extmem_wr_pkg::*;
#(
   parameter int CNT_W  = 6,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cfg_cycle,
   input  logic [CNT_W-1:0]  cfg_we_setup,
   input  logic [CNT_W-1:0]  cfg_we_pulse,
   input  logic [CNT_W-1:0]  cfg_cs_setup,
   input  logic [CNT_W-1:0]  cfg_cs_pulse,
   input  logic              cfg_we_ctrl,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_doe,
   output logic              mem_we_n,
   output logic              mem_cs_n,
   output logic              cfg_err
);
   initial begin
      assert (CNT_W >= 2)  else $error("CNT_W must be at least 2");
      assert (ADDR_W >= 1) else $error("ADDR_W must be at least 1");
      assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
   end

   wr_ctrl_e         ctrl_sel;
   logic             busy;
   logic [CNT_W-1:0] cnt;

   logic [CNT_W-1:0] setup_a  [NUM_STRB];
   logic [CNT_W-1:0] pulse_a  [NUM_STRB];
   logic             gov_a    [NUM_STRB];
   logic             strb_n_a [NUM_STRB];
   logic             win_a    [NUM_STRB];
   logic [NUM_STRB-1:0] bad_v;

   assign ctrl_sel         = wr_ctrl_e'(cfg_we_ctrl);
   assign setup_a[STRB_WE] = cfg_we_setup;
   assign pulse_a[STRB_WE] = cfg_we_pulse;
   assign gov_a[STRB_WE]   = (ctrl_sel == CTRL_BY_WE);
   assign setup_a[STRB_CS] = cfg_cs_setup;
   assign pulse_a[STRB_CS] = cfg_cs_pulse;
   assign gov_a[STRB_CS]   = (ctrl_sel == CTRL_BY_CS);

   for (genvar s = 0; s < NUM_STRB; s++) begin : g_strb
      wr_strobe_gen #(.CNT_W(CNT_W)) u_strb (
         .clk       (clk),
         .rst_n     (rst_n),
         .active    (busy),
         .cnt       (cnt),
         .cycle_len (cfg_cycle),
         .setup     (setup_a[s]),
         .pulse     (pulse_a[s]),
         .governs   (gov_a[s]),
         .strobe_n  (strb_n_a[s]),
         .past_setup(win_a[s]),
         .bad_cfg   (bad_v[s])
      );
   end

   assign cfg_err = |bad_v;

   wr_cycle_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cycle_len (cfg_cycle),
      .cfg_err   (cfg_err),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_addr  (req_addr),
      .req_data  (req_data),
      .busy      (busy),
      .cnt       (cnt),
      .addr_q    (mem_addr),
      .data_q    (mem_dout)
   );

   assign mem_we_n = strb_n_a[STRB_WE];
   assign mem_cs_n = strb_n_a[STRB_CS];
   assign mem_doe  = (ctrl_sel == CTRL_BY_WE) ? win_a[STRB_WE] : win_a[STRB_CS];

   assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (mem_we_n && mem_cs_n && !mem_doe));

   assert_doe_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_sel == CTRL_BY_WE && !mem_we_n) |-> mem_doe);

   assert_doe_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_sel == CTRL_BY_CS && !mem_cs_n) |-> mem_doe);
endmodule

// File: tb/tb_extmem_wr_seq.sv
`timescale 1ns/1ps
module tb_extmem_wr_seq;
   localparam int CW = 6;
   localparam int AW = 16;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cfg_cycle, cfg_we_setup, cfg_we_pulse, cfg_cs_setup, cfg_cs_pulse;
   logic          cfg_we_ctrl;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dout;
   logic          mem_doe, mem_we_n, mem_cs_n, cfg_err;

   always #2.5 clk = ~clk;

   extmem_wr_seq #(.CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) dut (.*);

   int checks = 0;
   int fails  = 0;
   bit live   = 0;

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // reference model state
   int m_act = 0, m_cnt = 0, m_addr = 0, m_data = 0;

   function automatic string err_tag();
      int s[2], p[2], g[2];
      s[0] = int'(cfg_we_setup); p[0] = int'(cfg_we_pulse); g[0] = cfg_we_ctrl;
      s[1] = int'(cfg_cs_setup); p[1] = int'(cfg_cs_pulse); g[1] = !cfg_we_ctrl;
      for (int i = 0; i < 2; i++) begin
         if (p[i] == 0) return "R8";
         if (s[i] + p[i] > int'(cfg_cycle)) return "R9";
         if (g[i] != 0 && s[i] == 0 && s[i] + p[i] == int'(cfg_cycle)) return "R10";
      end
      return "";
   endfunction

   function automatic int exp_ready();
      if (err_tag() != "") return 0;
      return (m_act == 0 || m_cnt == int'(cfg_cycle) - 1) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_cnt = 0; m_addr = 0; m_data = 0;
      end else if (req_valid && exp_ready() == 1) begin
         m_act = 1; m_cnt = 0; m_addr = int'(req_addr); m_data = int'(req_data);
      end else if (m_act == 1 && m_cnt == int'(cfg_cycle) - 1) begin
         m_act = 0; m_cnt = 0;
      end else if (m_act == 1) begin
         m_cnt++;
      end
   end

   always @(negedge clk) begin
      if (live) begin
         int ws, wp, cs, cp, dset, e_we, e_cs, e_doe;
         string tg;
         ws = int'(cfg_we_setup); wp = int'(cfg_we_pulse);
         cs = int'(cfg_cs_setup); cp = int'(cfg_cs_pulse);
         e_we = (m_act == 1 && m_cnt >= ws && m_cnt < ws + wp) ? 0 : 1;
         e_cs = (m_act == 1 && m_cnt >= cs && m_cnt < cs + cp) ? 0 : 1;
         dset = cfg_we_ctrl ? ws : cs;
         e_doe = (m_act == 1 && m_cnt >= dset) ? 1 : 0;
         tg = (m_act == 1) ? "R2" : "R4";
         chk(tg, "mem_we_n", int'(mem_we_n), e_we);
         chk(tg, "mem_cs_n", int'(mem_cs_n), e_cs);
         chk(cfg_we_ctrl ? "R5" : "R6", "mem_doe", int'(mem_doe), e_doe);
         chk("R1", "req_ready", int'(req_ready), exp_ready());
         chk("R7", "mem_addr", int'(mem_addr), m_addr);
         chk("R7", "mem_dout", int'(mem_dout), m_data);
         if (err_tag() != "") chk(err_tag(), "cfg_err", int'(cfg_err), 1);
         else                 chk("R10", "cfg_err clear", int'(cfg_err), 0);
      end
   end

   // run monitor for the continuity check
   bit mon = 0;
   int low_clks = 0, low_starts = 0;
   logic prev_we = 1'b1;
   always @(negedge clk) begin
      if (mon) begin
         if (!mem_we_n) low_clks++;
         if (!mem_we_n && prev_we) low_starts++;
      end
      prev_we = mem_we_n;
   end

   task automatic set_cfg(int cyc, int ws, int wp, int cs, int cp, bit mode);
      cfg_cycle = CW'(cyc); cfg_we_setup = CW'(ws); cfg_we_pulse = CW'(wp);
      cfg_cs_setup = CW'(cs); cfg_cs_pulse = CW'(cp); cfg_we_ctrl = mode;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send(int n, int base);
      for (int i = 0; i < n; i++) begin
         req_valid = 1'b1;
         req_addr  = AW'(base + i * 17);
         req_data  = DW'(base + i * 5 + 3);
         forever begin
            @(negedge clk);
            if (req_ready) begin
               @(posedge clk);
               #1;
               break;
            end
         end
      end
      req_valid = 1'b0;
   endtask

   // watchdog
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 20000) begin
         fails++; checks++;
         $display("FAIL watchdog: actual=%0d expected<=%0d", wd, 20000);
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      set_cfg(6, 1, 3, 0, 5, 1'b1);
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R4", "reset we_n", int'(mem_we_n), 1);
      chk("R4", "reset cs_n", int'(mem_cs_n), 1);
      chk("R4", "reset doe", int'(mem_doe), 0);
      chk("R1", "reset ready", int'(req_ready), 1);
      live = 1;
      idle(1);

      // write strobe governs, single then back-to-back
      send(1, 16'h1000);
      idle(8);
      send(3, 16'h2000);
      idle(8);

      // chip select governs; write strobe low through the whole run
      set_cfg(5, 0, 5, 1, 3, 1'b0);
      idle(2);
      low_clks = 0; low_starts = 0; mon = 1;
      send(3, 16'h3000);
      idle(7);
      mon = 0;
      chk("R3", "we_n low clocks over run", low_clks, 15);
      chk("R3", "we_n falling edges over run", low_starts, 1);

      // shortest legal cycle, back-to-back
      set_cfg(2, 0, 1, 0, 2, 1'b1);
      idle(2);
      send(4, 16'h4000);
      idle(4);

      // long hold on both strobes, chip select governs
      set_cfg(9, 2, 2, 1, 4, 1'b0);
      idle(2);
      send(2, 16'h5000);
      idle(12);

      // illegal: zero pulse; request must not start a cycle
      set_cfg(6, 1, 0, 0, 5, 1'b1);
      req_valid = 1'b1; req_addr = 16'hdead; req_data = 8'hbe;
      idle(5);
      req_valid = 1'b0;
      chk("R8", "addr untouched after refused request", int'(mem_addr), m_addr);

      // illegal: overrun of the cycle
      set_cfg(6, 1, 3, 3, 4, 1'b1);
      req_valid = 1'b1;
      idle(4);
      req_valid = 1'b0;

      // illegal when write strobe governs with no edge margin
      set_cfg(6, 0, 6, 1, 2, 1'b1);
      req_valid = 1'b1;
      idle(4);
      req_valid = 1'b0;

      // same timing legal when it does not govern
      set_cfg(6, 0, 6, 1, 2, 1'b0);
      idle(1);
      send(2, 16'h6000);
      idle(10);

      live = 0;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule